// File: doc/BRIEF.md
# SPI ADC Command Sequencer

This block is an SPI master that keeps a multichannel amplifier/ADC front end running with no processor involved. When `enable` goes high, it writes a fixed set of 16-bit configuration words and then sends one calibration word. After that it sends convert commands back to back. Each convert command carries the index of the next channel, so the slave cycles through all its channels for as long as `enable` stays high.

Every transfer is one 16-bit word, sent most-significant bit first in SPI mode 0. The serial clock comes from the system clock through an even divider. Chip-select stays high for a guard interval between words. Clearing `enable` lets the word in flight finish; the block then parks with chip-select high. The next time `enable` is set, the sequence starts again at the first configuration word. The slave's returning data line is routed straight to an external consumer and is never interpreted here.

Top module: `spi_adc_sequencer`

## Requirements
- R1: Each transfer drives `cs_n` low, produces exactly 16 rising edges of `sclk` while it is low, and presents the word most-significant bit first.
- R2: `sclk` is low whenever `cs_n` is high. `mosi` changes only while `sclk` is low, so it is stable at every rising edge.
- R3: One `sclk` period is `SCLK_DIV` system clocks: `SCLK_DIV/2` cycles high and `SCLK_DIV/2` cycles low. The default of 10 at 200 MHz gives 50 ns, which meets the 40.8 ns minimum.
- R4: Between two transfers, `cs_n` stays high for at least `GAP_PERIODS*SCLK_DIV` system clocks.
- R5: After reset or a restart, the first `N_CFG` words are the configuration words in index order 0 to `N_CFG-1`. Index k is bits [16k+15:16k] of `CFG_WORDS`.
- R6: The configuration words are followed by exactly one `CAL_WORD`.
- R7: Every later word is `CONV_TEMPLATE` with the field [`CH_LSB`+CW-1:`CH_LSB`] replaced by the channel index, where CW = clog2(`N_CH`). The channel starts at 0, increments by one per word, and wraps to 0 after `N_CH-1`.
- R8: `phase` reports the class of the current or most recent word: 1 = configuration, 2 = calibration, 3 = convert. It reads 0 when the block is idle and disabled. `busy` is high while a word or its guard interval is in progress.
- R9: When `enable` falls, the word in progress completes with all 16 clocks. The block then returns to `phase` 0 with `cs_n` high and starts no further word. The next `enable` begins again at configuration word 0.
- R10: `miso_out` follows `miso_in` combinationally.
- R11: While `rst_n` is low, `cs_n` is 1, `sclk` is 0, `mosi` is 0, `busy` is 0 and `phase` is 0, whatever the state of `enable`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request; a new run starts at configuration word 0 |
| miso_in | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Chip-select to the slave, active low |
| sclk | output | 1 | Serial clock to the slave, idles low |
| mosi | output | 1 | Serial command data to the slave |
| miso_out | output | 1 | Slave data routed to the external consumer |
| busy | output | 1 | High while a word or its guard interval is in progress |
| phase | output | 2 | 0 idle, 1 configuration, 2 calibration, 3 convert |

## Verification
The bench builds the block with the following parameters:
- three configuration words with distinct values;
- three channels, which is not a power of two;
- a 2-bit channel field at bit 8, inside a template whose field bits are all ones;
- the default divider of 10 and a guard of two periods.

With only three channels, the wrap from channel 2 back to 0 is reached within a few words. The ones in the template's field bits show whether the field is cleared before the channel index goes in. The short configuration list means a disable partway through a convert word, followed by a restart from configuration word 0, is reached early in the run.

// File: rtl/seq_pkg.sv
// Shared types for the SPI ADC command sequencer.
// Assumes: phase codes are visible on the top-level status port, so their
// encoding is fixed.
package seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_CONFIG  = 2'd1,
        PH_CALIB   = 2'd2,
        PH_CONVERT = 2'd3
    } phase_e;

endpackage

// File: rtl/spi_word_tx.sv
// Sends one word per start pulse in SPI mode 0, MSB first.
// After the last falling edge, chip-select is held high for a guard interval.
// Assumes: SCLK_DIV is even and at least 2; start is only honoured while ready.
module spi_word_tx #(
    parameter int WORD_W      = 16,
    parameter int SCLK_DIV    = 10,
    parameter int GAP_PERIODS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              ready,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi
);
    localparam int HALF     = SCLK_DIV / 2;
    localparam int TICK_W   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int GAP_CLKS = GAP_PERIODS * SCLK_DIV;
    localparam int GAP_W    = $clog2(GAP_CLKS + 1);
    localparam int BIT_W    = $clog2(WORD_W);

    typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_state_e;

    tx_state_e         state;
    logic [WORD_W-1:0] shreg;
    logic [TICK_W-1:0] tick;
    logic [BIT_W-1:0]  bit_n;
    logic [GAP_W-1:0]  gap;

    // Accept a word only when fully idle (guard interval elapsed).
    assign ready = (state == TX_IDLE);

    // Half-period timing, shifting on falling edges, and the guard interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cs_n  <= 1'b1;
            sclk  <= 1'b0;
            mosi  <= 1'b0;
            shreg <= '0;
            tick  <= '0;
            bit_n <= '0;
            gap   <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (start) begin
                        shreg <= word;
                        mosi  <= word[WORD_W-1];
                        cs_n  <= 1'b0;
                        tick  <= '0;
                        bit_n <= '0;
                        state <= TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (tick == TICK_W'(HALF - 1)) begin
                        tick <= '0;
                        sclk <= ~sclk;
                        if (sclk) begin
                            if (bit_n == BIT_W'(WORD_W - 1)) begin
                                cs_n  <= 1'b1;
                                mosi  <= 1'b0;
                                gap   <= '0;
                                state <= TX_GAP;
                            end else begin
                                bit_n <= bit_n + 1'b1;
                                shreg <= {shreg[WORD_W-2:0], 1'b0};
                                mosi  <= shreg[WORD_W-2];
                            end
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: begin
                    if (gap == GAP_W'(GAP_CLKS - 1)) begin
                        state <= TX_IDLE;
                    end else begin
                        gap <= gap + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/seq_word_sel.sv
// Picks the outgoing word from the current phase and counters.
// A convert word is the template with the channel index placed in a fixed field.
// Assumes: cfg_idx < N_CFG and ch < N_CH (guaranteed by the controller).
module seq_word_sel
    import seq_pkg::*;
#(
    parameter int                         WORD_W        = 16,
    parameter int                         N_CFG         = 18,
    parameter logic [N_CFG-1:0][WORD_W-1:0] CFG_WORDS   = {N_CFG{16'h0000}},
    parameter logic [WORD_W-1:0]          CAL_WORD      = 16'h5500,
    parameter logic [WORD_W-1:0]          CONV_TEMPLATE = 16'h0000,
    parameter int                         N_CH          = 32,
    parameter int                         CH_LSB        = 8,
    localparam int                        CFG_IW        = (N_CFG > 1) ? $clog2(N_CFG) : 1,
    localparam int                        CH_W          = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  phase_e            ph,
    input  logic [CFG_IW-1:0] cfg_idx,
    input  logic [CH_W-1:0]   ch,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] conv_word;

    // Channel field insertion; a single-channel slave uses the template as is.
    generate
        if (N_CH > 1) begin : g_ch_field
            localparam logic [WORD_W-1:0] FIELD_MASK =
                WORD_W'(((1 << CH_W) - 1) << CH_LSB);
            assign conv_word = (CONV_TEMPLATE & ~FIELD_MASK) |
                               (WORD_W'(ch) << CH_LSB);
        end else begin : g_no_field
            assign conv_word = CONV_TEMPLATE;
        end
    endgenerate

    // Word multiplexer by phase.
    always_comb begin
        case (ph)
            PH_CONFIG: word = CFG_WORDS[cfg_idx];
            PH_CALIB:  word = CAL_WORD;
            default:   word = conv_word;
        endcase
    end

endmodule

// File: rtl/seq_ctrl.sv
// Sequencer for the command stream: configuration list, then one calibration
// word, then round-robin convert words. A word is issued whenever the
// transmitter is idle and enable is high. A disabled, idle transmitter resets
// the sequence to configuration word 0.
// Assumes: start is taken by the transmitter in the same cycle it is raised.
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int  N_CFG  = 18,
    parameter int  N_CH   = 32,
    localparam int CFG_IW = (N_CFG > 1) ? $clog2(N_CFG) : 1,
    localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tx_ready,
    output logic              start,
    output phase_e            next_ph,
    output logic [CFG_IW-1:0] cfg_idx,
    output logic [CH_W-1:0]   ch,
    output phase_e            cur_ph
);
    // Issue a word whenever allowed.
    assign start = enable && tx_ready;

    // Advance the sequence on each issued word; rewind when parked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_ph <= PH_CONFIG;
            cfg_idx <= '0;
            ch      <= '0;
            cur_ph  <= PH_IDLE;
        end else if (start) begin
            cur_ph <= next_ph;
            case (next_ph)
                PH_CONFIG: begin
                    if (cfg_idx == CFG_IW'(N_CFG - 1)) begin
                        cfg_idx <= '0;
                        next_ph <= PH_CALIB;
                    end else begin
                        cfg_idx <= cfg_idx + 1'b1;
                    end
                end
                PH_CALIB: begin
                    ch      <= '0;
                    next_ph <= PH_CONVERT;
                end
                default: begin
                    ch <= (ch == CH_W'(N_CH - 1)) ? '0 : ch + 1'b1;
                end
            endcase
        end else if (tx_ready) begin
            next_ph <= PH_CONFIG;
            cfg_idx <= '0;
            ch      <= '0;
            cur_ph  <= PH_IDLE;
        end
    end

endmodule

// File: rtl/spi_adc_sequencer.sv
// Top level: autonomous SPI master that configures, calibrates and then
// continuously converts on a multichannel ADC front end. Slave data is routed
// to an external consumer untouched.
// Assumes: SCLK_DIV is even and long enough for the slave's minimum clock period.
module spi_adc_sequencer
    import seq_pkg::*;
#(
    parameter int                      WORD_W        = 16,
    parameter int                      SCLK_DIV      = 10,
    parameter int                      GAP_PERIODS   = 2,
    parameter int                      N_CFG         = 18,
    parameter logic [N_CFG-1:0][WORD_W-1:0] CFG_WORDS = {N_CFG{16'h0000}},
    parameter logic [WORD_W-1:0]       CAL_WORD      = 16'h5500,
    parameter logic [WORD_W-1:0]       CONV_TEMPLATE = 16'h0000,
    parameter int                      N_CH          = 32,
    parameter int                      CH_LSB        = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       miso_in,
    output logic       cs_n,
    output logic       sclk,
    output logic       mosi,
    output logic       miso_out,
    output logic       busy,
    output logic [1:0] phase
);
    localparam int CFG_IW = (N_CFG > 1) ? $clog2(N_CFG) : 1;
    localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic              tx_ready;
    logic              start;
    phase_e            next_ph;
    phase_e            cur_ph;
    logic [CFG_IW-1:0] cfg_idx;
    logic [CH_W-1:0]   ch;
    logic [WORD_W-1:0] word;

    seq_ctrl #(
        .N_CFG (N_CFG),
        .N_CH  (N_CH)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .tx_ready (tx_ready),
        .start    (start),
        .next_ph  (next_ph),
        .cfg_idx  (cfg_idx),
        .ch       (ch),
        .cur_ph   (cur_ph)
    );

    seq_word_sel #(
        .WORD_W        (WORD_W),
        .N_CFG         (N_CFG),
        .CFG_WORDS     (CFG_WORDS),
        .CAL_WORD      (CAL_WORD),
        .CONV_TEMPLATE (CONV_TEMPLATE),
        .N_CH          (N_CH),
        .CH_LSB        (CH_LSB)
    ) u_sel (
        .ph      (next_ph),
        .cfg_idx (cfg_idx),
        .ch      (ch),
        .word    (word)
    );

    spi_word_tx #(
        .WORD_W      (WORD_W),
        .SCLK_DIV    (SCLK_DIV),
        .GAP_PERIODS (GAP_PERIODS)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .word  (word),
        .ready (tx_ready),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .mosi  (mosi)
    );

    // Status and slave-data routing.
    assign busy     = ~tx_ready;
    assign phase    = cur_ph;
    assign miso_out = miso_in;

endmodule

// File: rtl/spi_adc_sequencer_chk.sv
// Protocol checker for spi_adc_sequencer, attached by bind.
// Counters in the checker measure clock high time and the chip-select guard.
module spi_adc_sequencer_chk #(
    parameter int SCLK_DIV    = 10,
    parameter int GAP_PERIODS = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       mosi,
    input logic       busy,
    input logic [1:0] phase
);
    localparam int unsigned HALF     = SCLK_DIV / 2;
    localparam int unsigned GAP_CLKS = GAP_PERIODS * SCLK_DIV;
    localparam int unsigned SAT      = GAP_CLKS + SCLK_DIV + 4;

    int unsigned hi_cnt;
    int unsigned cs_hi_cnt;

    // Length of the current sclk-high stretch and the cs_n-high stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt    <= 0;
            cs_hi_cnt <= SAT;
        end else begin
            hi_cnt    <= sclk ? ((hi_cnt < SAT) ? hi_cnt + 1 : hi_cnt) : 0;
            cs_hi_cnt <= cs_n ? ((cs_hi_cnt < SAT) ? cs_hi_cnt + 1 : cs_hi_cnt) : 0;
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R2
    AST_MOSI_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi)); // R2
    AST_SCLK_HIGH_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_cnt == HALF)); // R3
    AST_CS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (cs_hi_cnt >= GAP_CLKS)); // R4
    AST_BUSY_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy); // R8
    AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0) |-> cs_n); // R9

endmodule

bind spi_adc_sequencer spi_adc_sequencer_chk #(
    .SCLK_DIV    (SCLK_DIV),
    .GAP_PERIODS (GAP_PERIODS)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .mosi  (mosi),
    .busy  (busy),
    .phase (phase)
);

// File: tb/tb_spi_adc_sequencer.sv
`timescale 1ns/1ps
module tb_spi_adc_sequencer;
    localparam int DIV   = 10;
    localparam int GAPP  = 2;
    localparam int NCFG  = 3;
    localparam int NCH   = 3;
    localparam int NEXP  = 9;
    localparam logic [NCFG-1:0][15:0] CFGV = {16'h0F0F, 16'hBEEF, 16'h1234};

    // Expected stream: word, phase code, requirement tag.
    localparam logic [15:0] EXP_W [NEXP] = '{16'h1234, 16'hBEEF, 16'h0F0F, 16'hCA1B,
                                            16'hC0FF, 16'hC1FF, 16'hC2FF, 16'hC0FF, 16'hC1FF};
    localparam logic [1:0]  EXP_P [NEXP] = '{2'd1, 2'd1, 2'd1, 2'd2, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3};
    localparam string       EXP_R [NEXP] = '{"R5", "R5", "R5", "R6", "R7", "R7", "R7", "R7", "R7"};

    logic clk = 1'b0;
    logic rst_n, enable, miso_in;
    logic cs_n, sclk, mosi, miso_out, busy;
    logic [1:0] phase;

    always #2.5 clk = ~clk;

    spi_adc_sequencer #(
        .SCLK_DIV      (DIV),
        .GAP_PERIODS   (GAPP),
        .N_CFG         (NCFG),
        .CFG_WORDS     (CFGV),
        .CAL_WORD      (16'hCA1B),
        .CONV_TEMPLATE (16'hC3FF),
        .N_CH          (NCH),
        .CH_LSB        (8)
    ) dut (.*);

    int tests = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    // Word recorder driven only by the serial pins.
    logic [15:0] rec_w [64];
    int          rec_n [64];
    logic [1:0]  rec_p [64];
    int nw = 0, nb = 0;
    logic [15:0] sh;
    logic [1:0]  ph_cap;
    int last_rise = 0, per_min = 1000000, per_max = 0;
    int cs_rise = 0, gap_min = 1000000;

    always @(posedge clk) cyc++;

    always @(negedge cs_n) begin
        sh = '0;
        nb = 0;
        if (nw > 0 && (cyc - cs_rise) < gap_min) gap_min = cyc - cs_rise;
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (nb == 0) ph_cap = phase;
            else begin
                if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                if (cyc - last_rise > per_max) per_max = cyc - last_rise;
            end
            last_rise = cyc;
            sh = {sh[14:0], mosi};
            nb++;
        end
    end

    always @(posedge cs_n) begin
        cs_rise = cyc;
        if (nb > 0 && nw < 64) begin
            rec_w[nw] = sh;
            rec_n[nw] = nb;
            rec_p[nw] = ph_cap;
            nw++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_words(input int n);
        while (nw < n) @(negedge clk);
    endtask

    initial begin
        wait (cyc >= 100000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; miso_in = 1'b0;
        repeat (4) @(negedge clk);
        enable = 1'b1;                       // R11: enable ignored in reset
        repeat (4) @(negedge clk);
        chk("R11 cs_n", cs_n, 1);
        chk("R11 sclk", sclk, 0);
        chk("R11 mosi", mosi, 0);
        chk("R11 busy", busy, 0);
        chk("R11 phase", phase, 0);
        rst_n = 1'b1;

        // Table walk over the expected word stream.
        for (int k = 0; k < NEXP; k++) begin
            wait_words(k + 1);
            chk(EXP_R[k], rec_w[k], EXP_W[k]);
            chk("R1 clock count", rec_n[k], 16);
            chk("R8 phase", rec_p[k], EXP_P[k]);
        end

        while (cs_n) @(negedge clk);
        chk("R8 busy in word", busy, 1);
        chk("R3 period min", per_min, DIV);
        chk("R3 period max", per_max, DIV);
        tests++;
        if (gap_min < GAPP * DIV) begin
            fails++;
            $display("FAIL R4 gap actual=%0d expected>=%0d", gap_min, GAPP * DIV);
        end

        miso_in = 1'b1; #1;
        chk("R10 miso high", miso_out, 1);
        miso_in = 1'b0; #1;
        chk("R10 miso low", miso_out, 0);

        // R9: disable mid-word, then restart.
        begin
            int n0;
            while (cs_n) @(negedge clk);
            repeat (30) @(negedge clk);
            n0 = nw;
            enable = 1'b0;
            while (busy) @(negedge clk);
            repeat (2) @(negedge clk);
            chk("R9 word finished", nw, n0 + 1);
            chk("R9 full word", rec_n[n0], 16);
            chk("R9 phase idle", phase, 0);
            repeat (100) @(negedge clk);
            chk("R9 no new word", nw, n0 + 1);
            chk("R9 cs_n parked", cs_n, 1);
            chk("R2 sclk idle", sclk, 0);
            enable = 1'b1;
            wait_words(n0 + 2);
            chk("R9 restart word", rec_w[n0 + 1], 16'h1234);
            chk("R9 restart phase", rec_p[n0 + 1], 1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule